// File: doc/BRIEF.md
# Sticky Regulation Status Monitor

This block records how a power output has been regulated so that a host processor can inspect it. Three already-digitized indicators tell whether the constant-voltage loop, the positive current-limit loop or the negative current-limit loop is currently in control. From these the block decodes a fourth condition, unregulated, which means none of the three loops holds the output. Each of the four conditions has a flag that sets when the condition is entered and stays set until the host clears it. The host therefore sees every regulation mode the output has passed through since its last clear, even a short one.

Two more inputs, overvoltage trip and overtemperature, are passed straight into the status word without being latched, so the host always reads their present level. The host reads the whole 6-bit word with a read strobe qualified by a chip select. It clears the four sticky flags with a single-cycle clear pulse. All asynchronous indicator inputs are brought into the clock domain through a synchronizer before any decoding takes place.

Top module: `reg_status_monitor`

## Requirements
- R1: While `rst` is high and on the first read after it, all sticky flags are zero and `rd_data_o` is zero. Indicator inputs held at their idle level (all low) across reset do not record an unregulated entry.
- R2: The status word bit map is bit 0 constant-voltage flag, bit 1 positive current-limit flag, bit 2 negative current-limit flag, bit 3 live overvoltage, bit 4 live overtemperature, bit 5 unregulated flag.
- R3: A loop flag sets when its synchronized input goes from low to high, and it stays set after the input returns low.
- R4: The unregulated condition is true when none of the three loop inputs is high. Its flag sets when that condition is entered.
- R5: A one-cycle high pulse on `flag_clr_i` clears all four sticky flags. A condition that is still present after the clear does not set its flag again until it is left and entered anew.
- R6: If a flag's set event and a clear pulse fall in the same cycle, that flag ends set. Flags without a set event in that cycle are cleared.
- R7: Bits 3 and 4 follow the overvoltage and overtemperature inputs after synchronization and are never held.
- R8: `rd_data_o` is a register. It carries the status word one clock after a cycle in which `stat_cs_i` and `rd_i` are both high, and it is zero after any other cycle.
- R9: All five indicator inputs pass through a two-stage synchronizer. An input that is high for one full clock period is recorded. Its effect appears in a read issued four clock edges after the input changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_loop_i | input | 1 | Constant-voltage loop in control (asynchronous) |
| pcl_loop_i | input | 1 | Positive current-limit loop in control (asynchronous) |
| ncl_loop_i | input | 1 | Negative current-limit loop in control (asynchronous) |
| ovp_i | input | 1 | Overvoltage trip level (asynchronous, live) |
| therm_i | input | 1 | Overtemperature level (asynchronous, live) |
| flag_clr_i | input | 1 | Host clear of the sticky flags, synchronous pulse |
| stat_cs_i | input | 1 | Status chip select, synchronous |
| rd_i | input | 1 | Read strobe, synchronous |
| rd_data_o | output | 6 | Registered status word, zero when not read |

## Verification
The assertions assume that `flag_clr_i`, `stat_cs_i` and `rd_i` come from logic clocked by `clk`, so they hold steady around each edge. The loop and protection inputs may change at any time, and their properties are written only on the synchronized copies. The bench changes every input on the falling clock edge and holds each level for at least one full period, so no pulse is narrower than the synchronizer can capture. Set-wins timing is reached by counting the two synchronizer stages and the edge detector, then placing the clear pulse on the edge that registers the set.

// File: rtl/regmon_pkg.sv
package regmon_pkg;
  localparam int STAT_W     = 6;
  localparam int NUM_LOOPS  = 3;
  localparam int NUM_STICKY = NUM_LOOPS + 1;
  localparam int NUM_SYNC   = NUM_LOOPS + 2;

  // positions in the status word
  localparam int BIT_CV    = 0;
  localparam int BIT_PCL   = 1;
  localparam int BIT_NCL   = 2;
  localparam int BIT_OV    = 3;
  localparam int BIT_OT    = 4;
  localparam int BIT_UNREG = 5;

  // positions in the synchronized input vector
  localparam int SY_CV  = 0;
  localparam int SY_PCL = 1;
  localparam int SY_NCL = 2;
  localparam int SY_OV  = 3;
  localparam int SY_OT  = 4;

  // positions in the sticky condition vector
  localparam int ST_UNREG = NUM_STICKY - 1;

  // decoded level of each sticky condition while all loop inputs are idle
  localparam logic [NUM_STICKY-1:0] STICKY_IDLE = {1'b1, {NUM_LOOPS{1'b0}}};

  typedef struct packed {
    logic unreg;
    logic ot;
    logic ov;
    logic ncl;
    logic pcl;
    logic cv;
  } stat_word_t;
endpackage

// File: rtl/regmon_sync.sv
module regmon_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regmon_sticky.sv
module regmon_sticky #(
  parameter int            N        = 4,
  parameter logic [N-1:0]  IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] cond,
  output logic [N-1:0] flags
);
  logic [N-1:0] cond_q;
  logic [N-1:0] rise;

  // previous decoded level; starts at the idle decode so reset records nothing
  always_ff @(posedge clk) begin
    if (rst) cond_q <= IDLE_VAL;
    else     cond_q <= cond;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign rise[i] = cond[i] & ~cond_q[i];

    // a set event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= rise[i] | (flags[i] & ~clr);
    end

    p_set_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> flags[i]);

    p_hold_until_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr) |=> flags[i]);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr && !rise[i]) |=> !flags[i]);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (clr && rise[i]) |=> flags[i]);
  end
endmodule

// File: rtl/regmon_rdport.sv
module regmon_rdport #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs,
  input  logic         rd,
  input  logic [W-1:0] word,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst)           data <= '0;
    else if (cs && rd) data <= word;
    else               data <= '0;
  end

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> (data == '0));
endmodule

// File: rtl/reg_status_monitor.sv
module reg_status_monitor
  import regmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_loop_i,
  input  logic              pcl_loop_i,
  input  logic              ncl_loop_i,
  input  logic              ovp_i,
  input  logic              therm_i,
  input  logic              flag_clr_i,
  input  logic              stat_cs_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] rd_data_o
);
  logic [NUM_SYNC-1:0]   raw_in;
  logic [NUM_SYNC-1:0]   sync_q;
  logic [NUM_STICKY-1:0] cond;
  logic [NUM_STICKY-1:0] flags;
  stat_word_t            word;

  assign raw_in[SY_CV]  = cv_loop_i;
  assign raw_in[SY_PCL] = pcl_loop_i;
  assign raw_in[SY_NCL] = ncl_loop_i;
  assign raw_in[SY_OV]  = ovp_i;
  assign raw_in[SY_OT]  = therm_i;

  regmon_sync #(.W(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_q)
  );

  // loop conditions map straight through; unregulated when no loop holds
  assign cond[NUM_LOOPS-1:0] = sync_q[NUM_LOOPS-1:0];
  assign cond[ST_UNREG]      = ~|sync_q[NUM_LOOPS-1:0];

  regmon_sticky #(.N(NUM_STICKY), .IDLE_VAL(STICKY_IDLE)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .clr   (flag_clr_i),
    .cond  (cond),
    .flags (flags)
  );

  always_comb begin
    word.cv    = flags[SY_CV];
    word.pcl   = flags[SY_PCL];
    word.ncl   = flags[SY_NCL];
    word.ov    = sync_q[SY_OV];
    word.ot    = sync_q[SY_OT];
    word.unreg = flags[ST_UNREG];
  end

  regmon_rdport #(.W(STAT_W)) u_rdport (
    .clk  (clk),
    .rst  (rst),
    .cs   (stat_cs_i),
    .rd   (rd_i),
    .word (word),
    .data (rd_data_o)
  );

  p_ot_live_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_cs_i && rd_i) |=> (rd_data_o[BIT_OT] == $past(sync_q[SY_OT])));

  p_ov_live_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_cs_i && rd_i) |=> (rd_data_o[BIT_OV] == $past(sync_q[SY_OV])));

  p_unreg_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[ST_UNREG]) |-> $past(sync_q[NUM_LOOPS-1:0] == '0));
endmodule

// File: tb/test_reg_status_monitor.sv
`timescale 1ns/1ps
module test_reg_status_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cv = 1'b0, pcl = 1'b0, ncl = 1'b0, ov = 1'b0, ot = 1'b0;
  logic       clr = 1'b0, cs = 1'b0, rd = 1'b0;
  logic [5:0] rd_data;
  logic [5:0] got;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  reg_status_monitor i_reg_status_monitor (
    .clk        (clk),
    .rst        (rst),
    .cv_loop_i  (cv),
    .pcl_loop_i (pcl),
    .ncl_loop_i (ncl),
    .ovp_i      (ov),
    .therm_i    (ot),
    .flag_clr_i (clr),
    .stat_cs_i  (cs),
    .rd_i       (rd),
    .rd_data_o  (rd_data)
  );

  // entry: {clear_first, ncl, pcl, cv, ov, ot, expected[5:0]}
  // word bits: 0 cv, 1 +cl, 2 -cl, 3 ov, 4 ot, 5 unreg
  localparam int NVEC = 11;
  localparam logic [11:0] VEC [NVEC] = '{
    12'b1_000_0_0_000000, // R1 idle after reset records nothing
    12'b0_001_0_0_000001, // R3 cv entry
    12'b0_000_0_0_100001, // R4 unreg entry, R3 cv held
    12'b0_010_1_0_101011, // R3 +cl entry, R7 ov live
    12'b0_000_0_1_110011, // R7 ov drops, ot live
    12'b1_000_0_0_000000, // R5 clear, unreg still present, no re-set
    12'b0_100_0_0_000100, // R3 -cl entry
    12'b0_110_0_0_000110, // R3 +cl entry alongside -cl
    12'b1_110_1_1_011000, // R5 clear while loops held, R7 both live
    12'b0_000_0_0_100000, // R4 unreg entry
    12'b0_111_0_0_100111  // R2 all loop bits
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic read_word(output logic [5:0] v);
    @(negedge clk) begin cs = 1'b1; rd = 1'b1; end
    @(negedge clk) begin v = rd_data; cs = 1'b0; rd = 1'b0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    @(negedge clk) rst = 1'b0;
    read_word(got);
    chk("R1 reset state", got, 6'b000000);

    // vector walk
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][11]) pulse_clr();
      @(negedge clk) begin
        ncl = VEC[k][10]; pcl = VEC[k][9]; cv = VEC[k][8];
        ov  = VEC[k][7];  ot  = VEC[k][6];
      end
      wait_cyc(5);
      read_word(got);
      chk($sformatf("vector %0d R2 R3 R4 R5 R7", k), got, VEC[k][5:0]);
    end

    // R8 read gating: flags are 100111 here
    @(negedge clk) begin cs = 1'b1; rd = 1'b0; end
    @(negedge clk) chk("R8 cs without rd", rd_data, 6'b000000);
    @(negedge clk) begin cs = 1'b0; rd = 1'b1; end
    @(negedge clk) chk("R8 rd without cs", rd_data, 6'b000000);
    rd = 1'b0;
    read_word(got);
    chk("R8 qualified read", got, 6'b100111);
    @(negedge clk) chk("R8 bus returns to zero", rd_data, 6'b000000);

    // R9 one-cycle pulse is recorded
    @(negedge clk) begin cv = 1'b0; pcl = 1'b0; ncl = 1'b0; end
    wait_cyc(5);
    pulse_clr();
    @(negedge clk) pcl = 1'b1;
    @(negedge clk) pcl = 1'b0;
    wait_cyc(5);
    read_word(got);
    chk("R9 one-cycle pulse recorded", got, 6'b100010);

    // R6 clear on the edge that registers a cv set
    pulse_clr();
    @(negedge clk) cv = 1'b1;       // edge 1 sync, edge 2 sync, edge 3 flag
    @(negedge clk);
    @(negedge clk) clr = 1'b1;      // covers edge 3
    @(negedge clk) clr = 1'b0;
    wait_cyc(5);
    read_word(got);
    chk("R6 set wins over clear", got, 6'b000001);

    // R1 reset in mid run with inputs idle
    @(negedge clk) cv = 1'b0;
    wait_cyc(5);
    @(negedge clk) rst = 1'b1;
    wait_cyc(3);
    @(negedge clk) rst = 1'b0;
    wait_cyc(5);
    read_word(got);
    chk("R1 reset mid run", got, 6'b000000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule